// File: doc/BRIEF.md
# Modular Double-to-Word Converter

This block turns an IEEE binary64 operand into a 32-bit signed integer using wrap-around semantics, not saturation. The fraction is always dropped, so rounding is toward zero. Bits 31:0 of the exact, unbounded two's-complement integer are kept, and that word is sign-extended to the integer register width `XLEN`. Infinities and NaNs give zero. Two exception flags come out beside the result: invalid and inexact.

The operand is sampled on each rising clock edge, and the result and flags are registered. Inside, the data path has three stages:

- a field classifier that sorts the operand into zero, below-one, normal or special;
- an alignment shifter that places the binary point and collects the discarded bits;
- a sign stage that negates the word and decides the range and the flags.

Top module: `fcvt_mod_w`

## Requirements
- R1: While `rst_n` is low at a rising edge, the result and both flags become 0 at that edge.
- R2: For a finite operand whose value truncated toward zero lies in [-2^31, 2^31-1], the result is that truncated integer. The operand layout is bit 63 sign, bits 62:52 biased exponent (bias 1023), and bits 51:0 fraction.
- R3: For a finite operand whose truncated value lies outside the signed 32-bit range, the result word is bits 31:0 of the exact two's-complement integer. This is the magnitude's low 32 bits, negated modulo 2^32 when the sign is set.
- R4: The 32-bit word is sign-extended to `XLEN` bits. Bits `XLEN-1`:32 equal bit 31, and `XLEN` is 32 or 64.
- R5: An operand with exponent field all ones (either infinity or any NaN, of either sign) gives result 0 with invalid set and inexact clear.
- R6: Invalid is set for a finite operand exactly when its truncated value is below -2^31 or above 2^31-1.
- R7: Inexact is set exactly when invalid is clear and nonzero fraction bits were discarded. The two flags are never set together.
- R8: A finite operand with magnitude below 1 gives result 0 with invalid clear. This covers zero of either sign and subnormals. Inexact is set unless the operand is a zero.
- R9: The result and flags reflect the operand sampled at the previous rising edge. They do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 64 | binary64 operand |
| res_o | output | XLEN | Converted integer, sign-extended |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The wrap-around path and the fraction-detection path are both active on the same operand. Examples are -2^31 with a fraction, or a large value that also carries fraction bits. In those cases the range decision must be allowed to suppress inexact.

The bench provokes this by sweeping powers-of-two-scaled integer patterns with added sixteenths, in both signs, across the 2^31 boundary. Expected word and flags come from exact 128-bit arithmetic in the bench. Each vector is judged on the word and on the invalid/inexact pair together.

// File: rtl/fcvt_pkg.sv
// Shared constants and types for the double-to-word converter.
// Assumes IEEE binary64 input layout and a 32-bit destination word.
package fcvt_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int INT_W  = 32;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } dbl_t;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_TINY    = 2'd1,
        CLS_NORM    = 2'd2,
        CLS_SPECIAL = 2'd3
    } cls_e;
endpackage

// File: rtl/fcvt_classify.sv
// Sorts the operand fields into zero, below-one, normal (|x| >= 1) or
// special (infinity / NaN), and forms the significand and unbiased exponent.
// Assumes: k_o and sig_o are meaningful only when cls_o is CLS_NORM.
module fcvt_classify
    import fcvt_pkg::*;
(
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output cls_e              cls_o,
    output logic [EXP_W-1:0]  k_o,
    output logic [SIG_W-1:0]  sig_o
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [EXP_W-1:0] EXP_BIAS = EXP_W'(BIAS);

    // Class decision from exponent and fraction fields.
    always_comb begin
        if (exp_i == EXP_ONES)
            cls_o = CLS_SPECIAL;
        else if (exp_i == '0 && frac_i == '0)
            cls_o = CLS_ZERO;
        else if (exp_i < EXP_BIAS)
            cls_o = CLS_TINY;
        else
            cls_o = CLS_NORM;
    end

    // Unbiased exponent and significand with hidden one.
    always_comb begin
        k_o   = exp_i - EXP_BIAS;
        sig_o = {1'b1, frac_i};
    end
endmodule

// File: rtl/fcvt_align.sv
// Places the binary point of the significand: produces the low OUT_W bits
// of the truncated integer magnitude and a sticky bit for dropped fraction.
// Assumes k_i >= 0 (operand magnitude at least 1); OUT_W <= SIG_W.
module fcvt_align
    import fcvt_pkg::*;
#(
    parameter int OUT_W = INT_W
) (
    input  logic [SIG_W-1:0] sig_i,
    input  logic [EXP_W-1:0] k_i,
    output logic [OUT_W-1:0] mag_o,
    output logic             dropped_o,
    output logic             ge_half_o,
    output logic             eq_half_o
);
    localparam int POINT = SIG_W - 1;
    localparam int WIN   = SIG_W + OUT_W;
    localparam logic [EXP_W-1:0] K_POINT = EXP_W'(POINT);
    localparam logic [EXP_W-1:0] K_HALF  = EXP_W'(OUT_W - 1);
    localparam logic [EXP_W-1:0] K_OUT   = EXP_W'(OUT_W);

    logic [EXP_W-1:0] rsh;
    logic [EXP_W-1:0] lsh;

    // Shift distances either side of the binary point.
    always_comb begin
        rsh = K_POINT - k_i;
        lsh = k_i - K_POINT;
    end

    // Right shift drops fraction bits; left shift keeps only the low word.
    always_comb begin
        if (k_i <= K_POINT) begin
            mag_o     = OUT_W'(sig_i >> rsh);
            dropped_o = |(sig_i & ~({SIG_W{1'b1}} << rsh));
        end else if (lsh >= K_OUT) begin
            mag_o     = '0;
            dropped_o = 1'b0;
        end else begin
            mag_o     = OUT_W'({{OUT_W{1'b0}}, sig_i} << lsh);
            dropped_o = 1'b0;
        end
    end

    // Magnitude at or beyond 2^(OUT_W-1).
    always_comb begin
        ge_half_o = (k_i >= K_HALF);
        eq_half_o = (k_i == K_HALF);
    end

    initial begin
        if (WIN <= SIG_W) $error("fcvt_align: bad window");
    end
endmodule

// File: rtl/fcvt_sign.sv
// Applies the sign modulo 2^OUT_W, decides the signed range, and forms the
// invalid and inexact flags. Assumes mag_i is exact when eq_half_i is set.
module fcvt_sign
    import fcvt_pkg::*;
#(
    parameter int OUT_W = INT_W
) (
    input  cls_e             cls_i,
    input  logic             sign_i,
    input  logic [OUT_W-1:0] mag_i,
    input  logic             dropped_i,
    input  logic             ge_half_i,
    input  logic             eq_half_i,
    output logic [OUT_W-1:0] word_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    localparam logic [OUT_W-1:0] MIN_MAG = {1'b1, {(OUT_W-1){1'b0}}};

    logic is_norm;
    logic ovf;

    // Range test: only -2^(OUT_W-1) is allowed at the half-range magnitude.
    always_comb begin
        is_norm = (cls_i == CLS_NORM);
        ovf     = is_norm && ge_half_i &&
                  !(sign_i && eq_half_i && mag_i == MIN_MAG);
    end

    // Wrapped word with two's-complement negation.
    always_comb begin
        if (!is_norm)
            word_o = '0;
        else if (sign_i)
            word_o = ~mag_i + 1'b1;
        else
            word_o = mag_i;
    end

    // Flags; invalid takes precedence over inexact.
    always_comb begin
        invalid_o = (cls_i == CLS_SPECIAL) || ovf;
        inexact_o = !invalid_o &&
                    ((cls_i == CLS_TINY) || (is_norm && dropped_i));
    end
endmodule

// File: rtl/fcvt_mod_w.sv
// Top: modular binary64 -> 32-bit integer conversion, truncating, with the
// word sign-extended to XLEN. One register stage on the outputs.
// Assumes XLEN is 32 or 64; synchronous active-low reset.
module fcvt_mod_w
    import fcvt_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [63:0]     op_i,
    output logic [XLEN-1:0] res_o,
    output logic            invalid_o,
    output logic            inexact_o
);
    dbl_t             op;
    cls_e             cls;
    logic [EXP_W-1:0] k;
    logic [SIG_W-1:0] sig;
    logic [INT_W-1:0] mag;
    logic             dropped;
    logic             ge_half;
    logic             eq_half;
    logic [INT_W-1:0] word;
    logic             inv_c;
    logic             inx_c;
    logic [XLEN-1:0]  res_c;

    // Unpack the operand into its fields.
    always_comb op = op_i;

    fcvt_classify u_classify (
        .exp_i  (op.exp),
        .frac_i (op.frac),
        .cls_o  (cls),
        .k_o    (k),
        .sig_o  (sig)
    );

    fcvt_align #(.OUT_W(INT_W)) u_align (
        .sig_i     (sig),
        .k_i       (k),
        .mag_o     (mag),
        .dropped_o (dropped),
        .ge_half_o (ge_half),
        .eq_half_o (eq_half)
    );

    fcvt_sign #(.OUT_W(INT_W)) u_sign (
        .cls_i     (cls),
        .sign_i    (op.sign),
        .mag_i     (mag),
        .dropped_i (dropped),
        .ge_half_i (ge_half),
        .eq_half_i (eq_half),
        .word_o    (word),
        .invalid_o (inv_c),
        .inexact_o (inx_c)
    );

    // Width adaptation chosen by XLEN.
    generate
        if (XLEN == INT_W) begin : g_narrow
            always_comb res_c = word;
        end else if (XLEN > INT_W) begin : g_wide
            always_comb res_c = {{(XLEN-INT_W){word[INT_W-1]}}, word};
        end else begin : g_bad
            initial $error("fcvt_mod_w: XLEN must be 32 or 64");
            always_comb res_c = word[XLEN-1:0];
        end
    endgenerate

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o     <= '0;
            invalid_o <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            res_o     <= res_c;
            invalid_o <= inv_c;
            inexact_o <= inx_c;
        end
    end
endmodule

// File: rtl/fcvt_mod_w_chk.sv
// Checker for fcvt_mod_w: relates the sampled operand to the registered
// result and flags one edge later. Attached by bind below.
module fcvt_mod_w_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [63:0]     op_i,
    input logic [XLEN-1:0] res_o,
    input logic            invalid_o,
    input logic            inexact_o
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(invalid_o && inexact_o)); // R7

    AST_SPECIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[62:52]) == 11'h7FF)
        |-> (res_o == '0 && invalid_o && !inexact_o)); // R5

    AST_SMALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[62:52]) < 11'd1023)
        |-> (res_o == '0 && !invalid_o)); // R8

    AST_INTEGRAL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i[62:52]) >= 11'd1075 &&
         $past(op_i[62:52]) != 11'h7FF)
        |-> !inexact_o); // R7

    generate
        if (XLEN > 32) begin : g_ext
            AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
                res_o[XLEN-1:32] == {(XLEN-32){res_o[31]}}); // R4
        end
    endgenerate
endmodule

bind fcvt_mod_w fcvt_mod_w_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
);

// File: tb/test_fcvt_mod_w.sv
// Bench: directed corner cases plus a sweep of scaled integer patterns with
// added sixteenths; expectations from exact 128-bit arithmetic.
module test_fcvt_mod_w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op = '0;
    logic [63:0] res64;
    logic [31:0] res32;
    logic        inv64, inx64, inv32, inx32;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;

    always #5 clk = ~clk;

    fcvt_mod_w #(.XLEN(64)) i_fcvt_mod_w (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .res_o(res64), .invalid_o(inv64), .inexact_o(inx64));

    fcvt_mod_w #(.XLEN(32)) i_fcvt_mod_w_32 (
        .clk(clk), .rst_n(rst_n), .op_i(op),
        .res_o(res32), .invalid_o(inv32), .inexact_o(inx32));

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog R9: cycles=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(string tag, logic [63:0] e_res, logic e_inv, logic e_inx);
        checks = checks + 1;
        if (res64 !== e_res || inv64 !== e_inv || inx64 !== e_inx ||
            res32 !== e_res[31:0] || inv32 !== e_inv || inx32 !== e_inx) begin
            failures = failures + 1;
            $display("FAIL %s op=%h: res=%h/%h inv=%b/%b inx=%b/%b expected res=%h inv=%b inx=%b",
                     tag, op, res64, res32, inv64, inv32, inx64, inx32, e_res, e_inv, e_inx);
        end
    endtask

    task automatic apply(logic [63:0] bits);
        op = bits;
        @(negedge clk);
    endtask

    function automatic logic [63:0] sx(logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    initial begin
        logic [31:0] bases [12];
        int          fqs [4];
        bases = '{32'h0, 32'h1, 32'h3, 32'h5, 32'h7, 32'h7F, 32'hFF, 32'h155,
                  32'h1FFFFF, 32'h100000, 32'h12345, 32'hABCDE};
        fqs   = '{0, 1, 8, 15};

        // R1: reset clears outputs
        op = 64'h7FF0_0000_0000_0000;
        repeat (3) @(negedge clk);
        check("R1", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R9: output holds until next edge, then follows operand
        apply(64'h4059_0000_0000_0000);            // 100.0
        op = 64'hC059_0000_0000_0000;              // -100.0
        #2;
        check("R9", 64'd100, 1'b0, 1'b0);
        @(negedge clk);
        check("R9", sx(-32'sd100), 1'b0, 1'b0);

        // R5: infinities and NaNs
        apply(64'h7FF0_0000_0000_0000); check("R5", 64'h0, 1'b1, 1'b0);
        apply(64'hFFF0_0000_0000_0000); check("R5", 64'h0, 1'b1, 1'b0);
        apply(64'h7FF8_0000_0000_0000); check("R5", 64'h0, 1'b1, 1'b0);
        apply(64'hFFF0_0000_0000_0001); check("R5", 64'h0, 1'b1, 1'b0);

        // R8: zeros, subnormals, just below one
        apply(64'h8000_0000_0000_0000); check("R8", 64'h0, 1'b0, 1'b0);
        apply(64'h0000_0000_0000_0001); check("R8", 64'h0, 1'b0, 1'b1);
        apply(64'h800F_FFFF_FFFF_FFFF); check("R8", 64'h0, 1'b0, 1'b1);
        apply(64'h3FEF_FFFF_FFFF_FFFF); check("R8", 64'h0, 1'b0, 1'b1);

        // R6 / R3 / R7: range boundaries
        apply(64'h41DF_FFFF_FFC0_0000); check("R6", 64'h7FFF_FFFF, 1'b0, 1'b0);
        apply(64'hC1E0_0000_0000_0000); check("R6", 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0);
        apply(64'h41E0_0000_0000_0000); check("R3", 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0);
        apply(64'hC1E0_0000_0010_0000); check("R7", 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b1);
        apply(64'hC1E0_0000_0020_0000); check("R3", 64'h0000_0000_7FFF_FFFF, 1'b1, 1'b0);
        apply(64'h4330_0000_0000_0001); check("R3", 64'h1, 1'b1, 1'b0);   // 2^52+1
        apply(64'h7FEF_FFFF_FFFF_FFFF); check("R3", 64'h0, 1'b1, 1'b0);

        // Sweep: (-1)^s * (base*2^sh + fq/16)
        for (int s = 0; s < 2; s++) begin
            for (int bi = 0; bi < 12; bi++) begin
                for (int sh = 0; sh <= 70; sh++) begin
                    for (int fi = 0; fi < 4; fi++) begin
                        int           fq;
                        real          r;
                        logic [127:0] big;
                        logic [31:0]  e32;
                        logic         valid;
                        string        vtag;
                        string        ftag;
                        fq = fqs[fi];
                        if (fq != 0 && sh > 26) continue;
                        r = $itor(bases[bi]);
                        for (int j = 0; j < sh; j++) r = r * 2.0;
                        r = r + fq / 16.0;
                        big = 128'(bases[bi]) << sh;
                        valid = (s == 1) ? (big <= 128'h8000_0000) : (big < 128'h8000_0000);
                        e32 = (s == 1) ? (~big[31:0] + 32'd1) : big[31:0];
                        vtag = valid ? "R2" : "R3";
                        ftag = !valid ? "R6" : (big == 0 && fq != 0) ? "R8" : "R7";
                        apply($realtobits(r) | ((s == 1) ? 64'h8000_0000_0000_0000 : 64'h0));
                        check(vtag, sx(e32), !valid, valid && fq != 0);
                        check(ftag, sx(e32), !valid, valid && fq != 0);
                        checks = checks + 1;
                        if (res64[63:32] !== {32{res64[31]}}) begin
                            failures = failures + 1;
                            $display("FAIL R4 op=%h: upper=%h expected=%h",
                                     op, res64[63:32], {32{res64[31]}});
                        end
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule